// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block sits between the latched interrupt source flags of a small controller and its CPU. Twenty-six sources are folded onto ten vectors. Each vector is given one of two programmed levels. The block then decides whether the best pending request may preempt the level that is currently executing. When it may, the block presents the vector's entry address, the winning level, and the list of enabled source flags behind that vector. The CPU reads the flag list to see which source or sources caused the branch.

Taking an interrupt is signalled with `ack`, and leaving it with `reti`. Because a nested interrupt must always have a strictly higher level, at most three levels can be active at once. The nesting record is therefore kept as one bit per level, not as a stack of values. Pushing the program counter and detecting edges on pins are left to the surrounding logic.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset no level is active: `cur_level` is 0 (the base level), `depth` is 0, and `irq_req` is low while no source is pending.
- R2: A vector requests only when at least one of its sources has both its `src_flag` bit and its `src_en` bit set. A flag whose enable is clear has no effect on any output.
- R3: Level codes are 0 for base, 1 for L, 2 for H and 3 for X. When its `vec_hi` bit is 1, vector 1 or 2 runs at X and vectors 3 to 10 run at H. When the bit is 0, the vector runs at L. Vector n has the entry address 3 + 8*(n-1), which gives 0x03 up to 0x4B.
- R4: Among pending vectors, the one with the highest level wins.
- R5: Among pending vectors of equal level, the vector with the lowest number (the lowest address) wins.
- R6: `irq_req` is high only when the winning level is strictly greater than `cur_level`. While `irq_req` is low, `irq_vec_addr`, `irq_level` and `irq_flags` are all 0.
- R7: `irq_flags` bit k is the enabled flag of the k-th source of the winning vector. Bits above that vector's source count are 0.
- R8: `ack` while `irq_req` is high makes the winning level active on the next cycle: `cur_level` takes that level and `depth` rises by one. `ack` while `irq_req` is low changes nothing.
- R9: `reti` retires the current level on the next cycle and restores the previous one, down to the base level. `reti` at depth 0 is ignored. When `reti` and `ack` arrive in the same cycle, `reti` is served and `ack` is dropped.
- R10: Sources map to vectors in contiguous index ranges. Vector 1 takes source 0, vector 2 takes 1, vector 3 takes 2-4, vector 4 takes 5-7, vector 5 takes 8-9, vector 6 takes 10-12, vector 7 takes 13-15, vector 8 takes 16-17, vector 9 takes 18-20, and vector 10 takes 21-25. Within a vector, the source with the lower index goes to the lower `irq_flags` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_flag | input | 26 | Latched source flags |
| src_en | input | 26 | Per-source enables |
| vec_hi | input | 10 | Per-vector level select; bit 0 is vector 1 |
| ack | input | 1 | CPU takes the presented interrupt |
| reti | input | 1 | CPU returns from the current interrupt |
| irq_req | output | 1 | A request may preempt the current level |
| irq_vec_addr | output | 8 | Entry address of the winning vector |
| irq_level | output | 2 | Level of the winning vector |
| irq_flags | output | 8 | Enabled flags behind the winning vector |
| cur_level | output | 2 | Level now executing |
| depth | output | 2 | Number of active nested levels |

## Verification
The arbitration outputs (`irq_req`, the address, the level and the flag list) are combinational from the inputs and the active-level record. The bench therefore changes the inputs away from the clock edge and checks these outputs a few nanoseconds later, in the same cycle. `cur_level` and `depth` change only at the clock edge that samples `ack` or `reti`. The bench raises a strobe for exactly one cycle and checks these two outputs at the next falling edge, after that single register stage.

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int NVEC     = 10,
  parameter int NX       = 2,
  parameter logic [NVEC*4-1:0] GROUPS = {4'd5, 4'd3, 4'd2, 4'd3, 4'd3,
                                         4'd2, 4'd3, 4'd3, 4'd1, 4'd1},
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  parameter int AW       = 8,
  parameter int GMAX     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [off_of(NVEC)-1:0]     src_flag,
  input  logic [off_of(NVEC)-1:0]     src_en,
  input  logic [NVEC-1:0]             vec_hi,
  input  logic                        ack,
  input  logic                        reti,
  output logic                        irq_req,
  output logic [AW-1:0]               irq_vec_addr,
  output logic [1:0]                  irq_level,
  output logic [GMAX-1:0]             irq_flags,
  output logic [1:0]                  cur_level,
  output logic [1:0]                  depth
);

  function automatic int cnt_of(input int v);
    return int'(GROUPS[v*4 +: 4]);
  endfunction

  function automatic int off_of(input int v);
    int s;
    s = 0;
    for (int i = 0; i < v; i++) s += int'(GROUPS[i*4 +: 4]);
    return s;
  endfunction

  localparam int NSRC = off_of(NVEC);

  logic [NVEC-1:0][GMAX-1:0] gf;
  logic [NVEC-1:0]           vreq;
  logic [1:0]                best;
  int                        win;
  logic [3:0]                act;

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    localparam int C = cnt_of(v);
    localparam int O = off_of(v);
    for (genvar k = 0; k < GMAX; k++) begin : g_bit
      if (k < C) begin : g_src
        assign gf[v][k] = src_flag[O+k] & src_en[O+k];
      end else begin : g_pad
        assign gf[v][k] = 1'b0;
      end
    end
    assign vreq[v] = |gf[v];
  end

  always_comb begin
    logic [1:0] lv;
    best = 2'd0;
    win  = 0;
    for (int v = NVEC - 1; v >= 0; v--) begin
      if (!vreq[v])       lv = 2'd0;
      else if (!vec_hi[v]) lv = 2'd1;
      else if (v < NX)    lv = 2'd3;
      else                lv = 2'd2;
      if (lv != 2'd0 && lv >= best) begin
        best = lv;
        win  = v;
      end
    end
  end

  assign cur_level    = act[3] ? 2'd3 : act[2] ? 2'd2 : act[1] ? 2'd1 : 2'd0;
  assign depth        = 2'(act[1]) + 2'(act[2]) + 2'(act[3]);
  assign irq_req      = best > cur_level;
  assign irq_level    = irq_req ? best : 2'd0;
  assign irq_vec_addr = irq_req ? AW'(VEC_BASE + VEC_STEP * win) : '0;
  assign irq_flags    = irq_req ? gf[win] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      act <= 4'd0;
    else if (reti) begin
      if (act != 4'd0) act[cur_level] <= 1'b0;
    end else if (ack && irq_req)
      act[best] <= 1'b1;
  end

endmodule

module irq_level_arbiter_chk #(
  parameter int AW   = 8,
  parameter int GMAX = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack,
  input logic            reti,
  input logic            irq_req,
  input logic [AW-1:0]   irq_vec_addr,
  input logic [1:0]      irq_level,
  input logic [GMAX-1:0] irq_flags,
  input logic [1:0]      cur_level,
  input logic [1:0]      depth
);

  a_r6_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_level > cur_level);

  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec_addr == '0 && irq_flags == '0 && irq_level == 2'd0));

  a_r7_flags_present: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_flags != '0);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vec_addr[2:0] == 3'd3);

  a_r8_ack_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !reti) |=>
      (cur_level == $past(irq_level) && depth == $past(depth) + 2'd1));

  a_r9_reti_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && depth != 2'd0) |=>
      (depth == $past(depth) - 2'd1 && cur_level < $past(cur_level)));

  a_r9_reti_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && depth == 2'd0) |=> depth == 2'd0);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reti && !(ack && irq_req)) |=> ($stable(cur_level) && $stable(depth)));

endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(.AW(AW), .GMAX(GMAX)) u_chk (.*);

// File: tb/sim_irq_level_arbiter.sv
`timescale 1ns/1ps
module sim_irq_level_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] src_flag = '0;
  logic [25:0] src_en = '0;
  logic [9:0]  vec_hi = '0;
  logic        ack = 1'b0;
  logic        reti = 1'b0;
  logic        irq_req;
  logic [7:0]  irq_vec_addr;
  logic [1:0]  irq_level;
  logic [7:0]  irq_flags;
  logic [1:0]  cur_level;
  logic [1:0]  depth;

  int n_chk = 0;
  int n_bad = 0;
  int OFF[10] = '{0, 1, 2, 5, 8, 10, 13, 16, 18, 21};
  int CNT[10] = '{1, 1, 3, 3, 2, 3, 3, 2, 3, 5};

  always #10 clk = ~clk;

  irq_level_arbiter u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_src();
    src_flag = '0; src_en = '0; vec_hi = '0; #2;
  endtask

  task automatic raise(input int n, input int k, input bit hi);
    src_flag[OFF[n]+k] = 1'b1;
    src_en[OFF[n]+k]   = 1'b1;
    vec_hi[n]          = hi;
    #2;
  endtask

  task automatic pulse(input bit a, input bit r);
    ack = a; reti = r;
    @(negedge clk);
    ack = 1'b0; reti = 1'b0;
    #2;
  endtask

  task automatic t_reset();
    chk("R1 cur_level", cur_level, 0);
    chk("R1 depth", depth, 0);
    chk("R1 irq_req", irq_req, 0);
  endtask

  task automatic t_masking();
    clear_src();
    src_flag[3] = 1'b1; #2;
    chk("R2 masked flag no req", irq_req, 0);
    chk("R2 masked flag addr", irq_vec_addr, 0);
    src_en[3] = 1'b1; #2;
    chk("R2 enabled flag req", irq_req, 1);
    chk("R3 addr vec3", irq_vec_addr, 'h13);
    chk("R3 level L", irq_level, 1);
    chk("R7 flags vec3 src1", irq_flags, 'b010);
    src_flag[2] = 1'b1; #2;
    chk("R7 flag without enable ignored", irq_flags, 'b010);
    clear_src();
  endtask

  task automatic t_vectors();
    for (int n = 0; n < 10; n++) begin
      clear_src();
      raise(n, CNT[n] - 1, 1'b1);
      chk("R3 vector address", irq_vec_addr, 3 + 8 * n);
      chk("R3 elevated level", irq_level, n < 2 ? 3 : 2);
      chk("R10 top source of group", irq_flags, 1 << (CNT[n] - 1));
      vec_hi[n] = 1'b0; #2;
      chk("R3 low level", irq_level, 1);
    end
    clear_src();
    raise(9, 0, 1'b0); raise(9, 2, 1'b0); raise(9, 4, 1'b0);
    chk("R7 multi flags vec10", irq_flags, 'b10101);
    clear_src();
  endtask

  task automatic t_priority();
    clear_src();
    raise(1, 0, 1'b0); raise(9, 0, 1'b1);
    chk("R4 H beats L addr", irq_vec_addr, 'h4B);
    raise(0, 0, 1'b1);
    chk("R4 X beats H addr", irq_vec_addr, 'h03);
    clear_src();
    raise(8, 1, 1'b0); raise(3, 2, 1'b0);
    chk("R5 equal L lowest vector", irq_vec_addr, 'h1B);
    chk("R5 flags of winner", irq_flags, 'b100);
    clear_src();
    raise(5, 0, 1'b1); raise(2, 0, 1'b1);
    chk("R5 equal H lowest vector", irq_vec_addr, 'h13);
    clear_src();
  endtask

  task automatic t_nesting();
    clear_src();
    raise(8, 0, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R8 enter L level", cur_level, 1);
    chk("R8 depth one", depth, 1);
    chk("R6 same level blocked", irq_req, 0);
    raise(1, 0, 1'b0);
    chk("R6 other L vector blocked", irq_req, 0);
    raise(4, 1, 1'b1);
    chk("R6 H preempts L", irq_vec_addr, 'h23);
    pulse(1'b1, 1'b0);
    chk("R8 enter H level", cur_level, 2);
    raise(0, 0, 1'b1);
    chk("R6 X preempts H", irq_req, 1);
    pulse(1'b1, 1'b0);
    chk("R8 enter X level", cur_level, 3);
    chk("R8 depth three", depth, 3);
    chk("R6 nothing above X", irq_req, 0);
    pulse(1'b1, 1'b0);
    chk("R8 ack without req ignored", cur_level, 3);
    pulse(1'b0, 1'b1);
    chk("R9 back to H", cur_level, 2);
    pulse(1'b0, 1'b1);
    chk("R9 back to L", cur_level, 1);
    chk("R9 depth one", depth, 1);
    clear_src();
    raise(6, 0, 1'b1);
    pulse(1'b1, 1'b1);
    chk("R9 reti wins over ack level", cur_level, 0);
    chk("R9 reti wins over ack depth", depth, 0);
    clear_src();
    pulse(1'b0, 1'b1);
    chk("R9 reti at base ignored", depth, 0);
    pulse(1'b1, 1'b0);
    chk("R8 idle ack ignored", cur_level, 0);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); #2;
    t_reset();
    t_masking();
    t_vectors();
    t_priority();
    t_nesting();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule